// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset-Cause Flags

This block watches a small microcontroller for a stalled program. It counts
ticks of a slow time base and, when software fails to clear the count within
the chosen window, it pulses a reset request to the chip's reset controller.
The time base comes from a low-rate oscillator that is sampled in the system
clock domain and divided by eight. Each eighth rising edge of the oscillator
is one watchdog tick.

An 8-bit control register holds a 5-bit enable key and a 3-bit window select.
Only two key codes are legal. Any other key is treated as corruption, such as
a noisy write. In that case the timer halts, and after a fixed number of
system clocks the block requests a reset. A small flag register records which
cause fired: a key fault or a timeout. Software clears these flags by writing
zeros to them. The reset that the block itself requests leaves the flags
intact, and only power-on reset clears them.

Software reaches the block over a simple single-cycle register bus. A
one-cycle clear strobe restarts the count.

Top module: `keyed_wdt`

## Requirements
- R1: Power-on reset (`rst` high at a clock edge) sets the control register to 8'h53 (key 5'b01010, select 3'b011), clears both flags and holds `rst_req` low.
- R2: `osc_in` passes through two sampling flops in the system clock domain, and one watchdog tick is counted on every eighth rising edge it shows.
- R3: Control bits 2:0 select the window. Codes 3'b000 and 3'b001 both give 32 ticks, and code n from 3'b010 to 3'b111 gives 2^(n+4) ticks. With a steady oscillator, timeout pulses recur every window*8 oscillator periods.
- R4: When the tick count reaches the window, `rst_req` is high for exactly one cycle, the count restarts from zero, and flag bit 1 (timeout) is set.
- R5: A one-cycle `kick` returns the tick count to zero and leaves the control register unchanged. Kicking more often than the window prevents any timeout.
- R6: Control bits 7:3 equal to 5'b01010 or 5'b10101 mean enabled. Any other key stops tick counting. It also raises `rst_req` KEY_DELAY clock edges after the edge that wrote it, and again every KEY_DELAY edges while the key stays illegal. Each such pulse sets flag bit 0 (key fault).
- R7: Writing the flag register performs an AND with `bus_wdata[1:0]`: a 0 clears that flag and a 1 keeps it. A flag being set in the same cycle wins over the clear. Flag reads return zeros in bits 7:2.
- R8: Flags and the control register are not altered by the block's own `rst_req`. Only `rst` clears them.
- R9: A new window select applies at once. If the current count already meets the new window, `rst_req` rises on the clock edge after the write.
- R10: `bus_addr` 0 selects the control register and `bus_addr` 1 selects the flag register. `bus_rdata` follows the addressed register combinationally. Writes take effect at the clock edge where `bus_we` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| osc_in | input | 1 | Low-rate oscillator level, sampled by clk |
| kick | input | 1 | One-cycle strobe that restarts the tick count |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 1 | Register select: 0 control, 1 flags |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| rst_req | output | 1 | One-cycle chip reset request |

## Verification
The bench targets several corner cases:
- The duplicated shortest window. A design that decoded select code 000 as a 16-tick window would fire twice as often.
- Shrinking the window while the count is past the new limit. An equality compare would then miss the limit and run until the count wrapped.
- The key-fault delay and its repetition. An off-by-one in the delay counter, or a timer that keeps counting under an illegal key, shows up as a shifted or extra pulse.
- A flag clear that collides with a flag set, which must not lose the event.
- Flags that survive the block's own reset request.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int CTRL_W = 8;
    localparam int KEY_W  = 5;
    localparam int SEL_W  = 3;
    localparam int FLAG_W = 2;

    localparam logic [KEY_W-1:0]  KEY_ON_A = 5'b01010;
    localparam logic [KEY_W-1:0]  KEY_ON_B = 5'b10101;
    localparam logic [CTRL_W-1:0] CTRL_POR = 8'b0101_0011;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    typedef struct packed {
        logic timeout;
        logic key_fault;
    } flags_t;

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_FLAG = 1'b1
    } reg_sel_e;

    function automatic logic key_is_legal(input logic [KEY_W-1:0] k);
        return (k == KEY_ON_A) || (k == KEY_ON_B);
    endfunction

    function automatic int unsigned window_exp(input logic [SEL_W-1:0] s,
                                               input int unsigned min_exp);
        if (s <= SEL_W'(1))
            return min_exp;
        return min_exp + int'(s) - 1;
    endfunction

endpackage

// File: rtl/kwdt_tick_gen.sv
module kwdt_tick_gen #(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_DIV     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_in,
    output logic tick
);
    localparam int PRE_W = $clog2(PRE_DIV);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   osc_prev_q;
    logic [PRE_W-1:0]       pre_q;
    logic                   osc_rise;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= osc_in;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], osc_in};
            end
        end
    endgenerate

    assign osc_rise = sync_q[SYNC_STAGES-1] & ~osc_prev_q;
    assign tick     = osc_rise && (pre_q == PRE_W'(PRE_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_prev_q <= 1'b0;
            pre_q      <= '0;
        end else begin
            osc_prev_q <= sync_q[SYNC_STAGES-1];
            if (osc_rise)
                pre_q <= (pre_q == PRE_W'(PRE_DIV - 1)) ? '0 : pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/kwdt_timeout_ctr.sv
module kwdt_timeout_ctr
    import kwdt_pkg::*;
#(
    parameter int MIN_EXP = 5,
    localparam int MAX_EXP = MIN_EXP + (1 << SEL_W) - 2,
    localparam int CNT_W   = MAX_EXP + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             kick,
    input  logic             halt,
    input  logic [SEL_W-1:0] sel,
    output logic             fire,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] next_cnt;

    assign term     = CNT_W'(1) << window_exp(sel, MIN_EXP);
    assign next_cnt = count + CNT_W'(tick);
    assign fire     = !halt && !kick && (next_cnt >= term);

    always_ff @(posedge clk) begin
        if (rst)                      count <= '0;
        else if (halt || kick || fire) count <= '0;
        else                          count <= next_cnt;
    end
endmodule

// File: rtl/kwdt_key_guard.sv
module kwdt_key_guard
    import kwdt_pkg::*;
#(
    parameter int DELAY = 4,
    localparam int DLY_W = (DELAY > 2) ? $clog2(DELAY) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] key,
    output logic             key_bad,
    output logic             fire
);
    logic [DLY_W-1:0] wait_q;

    assign key_bad = !key_is_legal(key);
    assign fire    = key_bad && (wait_q == DLY_W'(DELAY - 1));

    always_ff @(posedge clk) begin
        if (rst || !key_bad) wait_q <= '0;
        else if (fire)       wait_q <= '0;
        else                 wait_q <= wait_q + DLY_W'(1);
    end
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              addr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              set_key_fault,
    input  logic              set_timeout,
    output ctrl_t             ctrl,
    output flags_t            flags,
    output logic [CTRL_W-1:0] rdata
);
    flags_t flags_nxt;
    reg_sel_e sel_reg;

    assign sel_reg = reg_sel_e'(addr);

    always_comb begin
        flags_nxt = flags;
        if (we && sel_reg == REG_FLAG)
            flags_nxt = flags & flags_t'(wdata[FLAG_W-1:0]);
        if (set_key_fault) flags_nxt.key_fault = 1'b1;
        if (set_timeout)   flags_nxt.timeout   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= ctrl_t'(CTRL_POR);
            flags <= '0;
        end else begin
            if (we && sel_reg == REG_CTRL)
                ctrl <= ctrl_t'(wdata);
            flags <= flags_nxt;
        end
    end

    always_comb begin
        case (sel_reg)
            REG_CTRL: rdata = ctrl;
            default:  rdata = {{(CTRL_W-FLAG_W){1'b0}}, flags};
        endcase
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_DIV     = 8,
    parameter int MIN_EXP     = 5,
    parameter int KEY_DELAY   = 4,
    localparam int CNT_W      = MIN_EXP + (1 << SEL_W) - 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_in,
    input  logic        kick,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        rst_req
);
    ctrl_t            ctrl_q;
    flags_t           flags_q;
    logic             tick;
    logic             key_bad;
    logic             key_fire;
    logic             tmo_fire;
    logic [CNT_W-1:0] tmo_count;

    kwdt_tick_gen #(.SYNC_STAGES(SYNC_STAGES), .PRE_DIV(PRE_DIV)) u_tick (
        .clk(clk), .rst(rst), .osc_in(osc_in), .tick(tick)
    );

    kwdt_key_guard #(.DELAY(KEY_DELAY)) u_guard (
        .clk(clk), .rst(rst), .key(ctrl_q.key),
        .key_bad(key_bad), .fire(key_fire)
    );

    kwdt_timeout_ctr #(.MIN_EXP(MIN_EXP)) u_ctr (
        .clk(clk), .rst(rst), .tick(tick), .kick(kick), .halt(key_bad),
        .sel(ctrl_q.sel), .fire(tmo_fire), .count(tmo_count)
    );

    kwdt_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .set_key_fault(key_fire), .set_timeout(tmo_fire),
        .ctrl(ctrl_q), .flags(flags_q), .rdata(bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) rst_req <= 1'b0;
        else     rst_req <= key_fire | tmo_fire;
    end
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             kick,
    input logic             rst_req,
    input logic             bus_addr,
    input logic [7:0]       bus_rdata,
    input logic             key_bad,
    input logic             key_fire,
    input logic             tmo_fire,
    input logic [1:0]       flags,
    input logic [CNT_W-1:0] count
);
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    a_r4_timeout_flag: assert property (@(posedge clk) disable iff (rst)
        tmo_fire |=> flags[1]);

    a_r6_fault_flag: assert property (@(posedge clk) disable iff (rst)
        key_fire |=> flags[0]);

    a_r6_timer_halted: assert property (@(posedge clk) disable iff (rst)
        key_bad |-> !tmo_fire);

    a_r5_kick_clears: assert property (@(posedge clk) disable iff (rst)
        kick |=> (count == '0));

    a_r8_flag_with_req: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (flags != 2'b00));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_addr |-> (bus_rdata[7:2] == 6'd0));
endmodule

bind keyed_wdt kwdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .kick(kick), .rst_req(rst_req),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .key_bad(key_bad),
    .key_fire(key_fire), .tmo_fire(tmo_fire), .flags(flags_q),
    .count(tmo_count)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
    localparam int DLY = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_in = 1'b0;
    logic       kick = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    int osc_half = 2;
    int osc_ph   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    keyed_wdt u_dut (
        .clk(clk), .rst(rst), .osc_in(osc_in), .kick(kick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    // ---------------- reference model built from the requirements
    logic [7:0]  m_ctrl  = 8'h53;
    logic [1:0]  m_flags = 2'b00;
    logic [1:0]  m_sync  = 2'b00;
    logic        m_prev  = 1'b0;
    int          m_pre   = 0;
    int          m_cnt   = 0;
    int          m_bad   = 0;
    logic        m_req   = 1'b0;

    function automatic int window_ticks(input logic [2:0] s);
        if (s < 3'd2) return 32;
        return 1 << (int'(s) + 4);
    endfunction

    function automatic bit legal_key(input logic [4:0] k);
        return (k == 5'b01010) || (k == 5'b10101);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 8'h53; m_flags = 2'b00; m_sync = 2'b00; m_prev = 1'b0;
            m_pre = 0; m_cnt = 0; m_bad = 0; m_req = 1'b0;
        end else begin
            bit rise, tk, bad, kf, tf;
            int nxt;
            rise = m_sync[1] && !m_prev;
            tk   = rise && (m_pre == 7);
            bad  = !legal_key(m_ctrl[7:3]);
            nxt  = m_cnt + int'(tk);
            tf   = !bad && !kick && (nxt >= window_ticks(m_ctrl[2:0]));
            kf   = bad && (m_bad == DLY - 1);
            m_cnt = (bad || kick || tf) ? 0 : nxt;
            m_bad = (!bad || kf) ? 0 : m_bad + 1;
            m_req = tf || kf;
            if (bus_we && bus_addr)  m_flags = m_flags & bus_wdata[1:0];
            if (kf) m_flags[0] = 1'b1;
            if (tf) m_flags[1] = 1'b1;
            if (bus_we && !bus_addr) m_ctrl = bus_wdata;
            if (rise) m_pre = (m_pre + 1) % 8;
            m_prev = m_sync[1];
            m_sync = {m_sync[0], osc_in};
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: compare at the falling edge, then move the oscillator and drop strobes
    task automatic cyc();
        logic [7:0] exp_rd;
        @(negedge clk);
        exp_rd = bus_addr ? {6'd0, m_flags} : m_ctrl;
        check(rst_req === m_req, "R4 R6 model rst_req", int'(rst_req), int'(m_req));
        check(bus_rdata === exp_rd, "R10 model rdata", int'(bus_rdata), int'(exp_rd));
        osc_ph++;
        if (osc_ph >= osc_half) begin osc_ph = 0; osc_in = ~osc_in; end
        bus_we = 1'b0;
        kick = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
    endtask

    task automatic until_req(input int limit, output int n);
        n = 0;
        do begin cyc(); n++; end while (!rst_req && n < limit);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int n;
        void'($urandom(32'h5eed_0b0e));
        do_reset();

        // R1 reset state
        bus_addr = 1'b0; cyc();
        check(bus_rdata == 8'h53, "R1 ctrl after reset", bus_rdata, 8'h53);
        bus_addr = 1'b1; cyc();
        check(bus_rdata == 8'h00, "R1 flags after reset", bus_rdata, 0);
        check(rst_req == 1'b0, "R1 rst_req low", rst_req, 0);

        // R2 R3 R4 steady-state periods, including duplicated shortest window
        for (int s = 0; s < 4; s++) begin
            wr(1'b0, {5'b01010, 3'(s)});
            until_req(20000, n);
            until_req(20000, n);
            check(n == window_ticks(3'(s)) * 8 * 2 * osc_half, $sformatf("R3 period sel=%0d", s),
                  n, window_ticks(3'(s)) * 16 * osc_half);
            cyc();
            check(rst_req == 1'b0, "R4 pulse one cycle", rst_req, 0);
            bus_addr = 1'b1; cyc();
            check(bus_rdata[1] == 1'b1, "R4 timeout flag", bus_rdata, 2);
        end

        // R7 keep with 1, clear with 0
        wr(1'b1, 8'hFF); cyc();
        check(bus_rdata[1] == 1'b1, "R7 write one keeps", bus_rdata, 2);
        wr(1'b1, 8'h00); cyc();
        check(bus_rdata == 8'h00, "R7 write zero clears", bus_rdata, 0);

        // R5 kicking faster than the window prevents timeout; ctrl kept
        wr(1'b0, 8'b01010_000);
        n = 0;
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) kick = 1'b1;
            cyc();
            if (rst_req) n++;
        end
        check(n == 0, "R5 kicks prevent timeout", n, 0);
        bus_addr = 1'b0; cyc();
        check(bus_rdata == 8'b01010_000, "R5 ctrl unchanged by kick", bus_rdata, 8'h50);

        // R9 shrinking the window past the count fires on the next edge
        wr(1'b0, 8'b10101_011);
        kick = 1'b1; cyc();
        repeat (1400) cyc();
        wr(1'b0, 8'b10101_000);
        n = 1;
        while (!rst_req && n < 10) begin cyc(); n++; end
        check(n == 2, "R9 select change immediate", n, 2);

        // R6 illegal key: delayed, repeating, flag set, timer halted
        wr(1'b1, 8'h00);
        bus_wdata = 8'b00000_011; bus_we = 1'b1; bus_addr = 1'b0;
        until_req(100, n);
        check(n == DLY + 1, "R6 key fault delay", n, DLY + 1);
        until_req(100, n);
        check(n == DLY, "R6 key fault repeats", n, DLY);
        bus_addr = 1'b1; cyc();
        check(bus_rdata == 8'h01, "R6 key fault flag only", bus_rdata, 1);
        // R8 own reset request leaves ctrl and flags
        bus_addr = 1'b0; cyc();
        check(bus_rdata == 8'h03, "R8 ctrl survives rst_req", bus_rdata, 3);
        wr(1'b0, 8'b10101_000);
        n = 0;
        for (int i = 0; i < 20; i++) begin cyc(); if (rst_req) n++; end
        check(n == 0, "R6 legal key stops faults", n, 0);
        bus_addr = 1'b1; cyc();
        check(bus_rdata[0] == 1'b1, "R8 flag survives rst_req", bus_rdata, 1);
        do_reset();
        cyc();
        check(bus_rdata == 8'h00, "R8 power-on reset clears flags", bus_rdata, 0);

        // R7 clear colliding with a set: set wins
        wr(1'b0, 8'b11111_000);
        repeat (DLY - 1) cyc();
        bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h00;
        cyc();
        cyc();
        check(bus_rdata[0] == 1'b1, "R7 set wins over clear", bus_rdata, 1);
        wr(1'b0, 8'b01010_001);

        // constrained random mix checked against the model every cycle
        for (int seg = 1; seg <= 3; seg++) begin
            osc_half = seg;
            for (int i = 0; i < 12000; i++) begin
                int r;
                r = int'($urandom_range(0, 999));
                bus_addr = 1'($urandom_range(0, 1));
                if (r < 3) begin
                    bus_we = 1'b1; bus_addr = 1'b0;
                    bus_wdata[2:0] = 3'($urandom_range(0, 3));
                    bus_wdata[7:3] = ($urandom_range(0, 9) == 0) ? 5'($urandom)
                                   : (($urandom_range(0, 1) == 1) ? 5'b01010 : 5'b10101);
                end else if (r < 6) begin
                    bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'($urandom);
                end else if (r < 10) begin
                    kick = 1'b1;
                end
                cyc();
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule